// File: doc/BRIEF.md
# Code Memory Lock Controller

This block turns a small set of non-volatile lock bits into access permissions for a microcontroller core. The core raises flags for three kinds of access. The first is a table-read instruction that runs from external code memory and targets internal code. The second is a programming request and the third is a verify request. The block answers each flag with a grant in the same cycle, using only the current lock state.

Protection is cumulative. Each programmed bit adds restrictions on top of those already in force. Once the lowest lock bit is programmed, the external-access strap no longer steers code fetches directly. Its level is captured while reset is held, and that captured value selects the fetch source until the next reset. A mismatch flag reports when the captured level and the live pin disagree. At the top level, a fetch that would go to external memory is refused altogether.

The core uses the fetch-source select to route instruction fetches. It uses the grants to gate its table-read, program and verify sequences.

Top module: `code_lock_ctrl`

## Requirements
- R1: Bit i of `lockBits` is 1 when programmed. The protection level is i+1 for the highest programmed bit i, or 0 when no bit is programmed.
- R2: At level 0, every raised request is granted. `fetchExternal` equals the inverse of the live `extAccessPin` (pin low selects external memory for the whole 64 KiB code space).
- R3: At level 1 or above, table reads and programming requests are refused.
- R4: Verify requests are granted at levels 0 and 1 and refused at level 2 or above.
- R5: At level 3, `fetchExternal` is 0. `extFetchBlocked` is 1 whenever the effective strap level is low, and 0 whenever it is high.
- R6: On every rising clock edge while `rstN` is low, `extAccessLatched` takes the value of `extAccessPin`. After reset is released it holds that value until the next reset.
- R7: At level 1 or above, the fetch source follows `extAccessLatched`, so live changes on the pin do not affect `fetchExternal`.
- R8: `strapMismatch` is 1 exactly when `rstN` is high, the level is at least 1, and `extAccessLatched` differs from `extAccessPin`.
- R9: Grants and denials are combinational. A request is answered in the cycle in which it is raised, before any clock edge.
- R10: Bit patterns outside the four legal ones take the level of their highest programmed bit. Pattern 010 acts as level 2 and patterns 100 and 110 act as level 3.
- R11: A grant output is never 1 while its request input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the strap is sampled while it is low |
| lockBits | input | NUM_LOCK_BITS | Lock bits, 1 = programmed |
| extAccessPin | input | 1 | Live external-access strap, low = external fetch |
| reqTableRead | input | 1 | Table read from external code targeting internal code |
| reqProgram | input | 1 | Programming request |
| reqVerify | input | 1 | Verify request |
| grantTableRead | output | 1 | Table read permitted |
| grantProgram | output | 1 | Programming permitted |
| grantVerify | output | 1 | Verify permitted |
| extAccessLatched | output | 1 | Strap level captured during reset |
| fetchExternal | output | 1 | 1 = fetch code from external memory |
| extFetchBlocked | output | 1 | External fetch wanted but refused at top level |
| strapMismatch | output | 1 | Captured strap differs from live pin while locked |

## Verification
The bench moves the live pin after reset at a locked level. A design that read the pin live would change the fetch source and would never raise the mismatch flag. It also re-resets with the opposite strap to show the captured value follows the new reset and not the old one. Illegal bit patterns such as 010 and 100 are applied. A decoder that keyed only on the legal patterns would grant programming or allow external fetch there. Requests are raised and checked between clock edges, so a registered grant would show up one cycle late and be caught.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;
  // Strobes from the level decoder to the permission datapath
  typedef struct packed {
    logic useLatch;      // level >= 1: strap taken from capture
    logic blockTblRead;  // level >= 1
    logic blockProgram;  // level >= 1
    logic blockVerify;   // level >= 2
    logic blockExtExec;  // top level
  } lockStrobe_t;
endpackage

// File: rtl/code_lock_ctl.sv
module code_lock_ctl #(
  parameter int NUM_LOCK_BITS = 3
) (
  input  logic [NUM_LOCK_BITS-1:0] lockBits,
  output code_lock_pkg::lockStrobe_t strobes
);
  localparam int LVL_W = $clog2(NUM_LOCK_BITS + 1);
  localparam int VERIFY_LVL = (NUM_LOCK_BITS >= 2) ? 2 : 1;

  logic [LVL_W-1:0] level;

  // highest programmed bit sets the level, so odd patterns round up
  always_comb begin
    level = '0;
    for (int i = 0; i < NUM_LOCK_BITS; i++) begin
      if (lockBits[i]) level = LVL_W'(i + 1);
    end
  end

  always_comb begin
    strobes.useLatch     = int'(level) >= 1;
    strobes.blockTblRead = int'(level) >= 1;
    strobes.blockProgram = int'(level) >= 1;
    strobes.blockVerify  = int'(level) >= VERIFY_LVL;
    strobes.blockExtExec = int'(level) >= NUM_LOCK_BITS;
  end
endmodule

// File: rtl/code_lock_dp.sv
module code_lock_dp (
  input  logic clk,
  input  logic rstN,
  input  logic extAccessPin,
  input  logic reqTableRead,
  input  logic reqProgram,
  input  logic reqVerify,
  input  code_lock_pkg::lockStrobe_t strobes,
  output logic grantTableRead,
  output logic grantProgram,
  output logic grantVerify,
  output logic extAccessLatched,
  output logic fetchExternal,
  output logic extFetchBlocked,
  output logic strapMismatch
);
  logic strapHeld;
  logic effStrap;
  logic wantExt;

  // capture follows the pin for as long as reset is held
  always_ff @(posedge clk) begin
    if (!rstN) strapHeld <= extAccessPin;
  end

  always_comb begin
    effStrap         = strobes.useLatch ? strapHeld : extAccessPin;
    wantExt          = !effStrap;
    fetchExternal    = wantExt && !strobes.blockExtExec;
    extFetchBlocked  = wantExt && strobes.blockExtExec;
    strapMismatch    = rstN && strobes.useLatch && (strapHeld != extAccessPin);
    grantTableRead   = reqTableRead && !strobes.blockTblRead;
    grantProgram     = reqProgram && !strobes.blockProgram;
    grantVerify      = reqVerify && !strobes.blockVerify;
    extAccessLatched = strapHeld;
  end
endmodule

// File: rtl/code_lock_ctrl.sv
module code_lock_ctrl #(
  parameter int NUM_LOCK_BITS = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_LOCK_BITS-1:0] lockBits,
  input  logic                     extAccessPin,
  input  logic                     reqTableRead,
  input  logic                     reqProgram,
  input  logic                     reqVerify,
  output logic                     grantTableRead,
  output logic                     grantProgram,
  output logic                     grantVerify,
  output logic                     extAccessLatched,
  output logic                     fetchExternal,
  output logic                     extFetchBlocked,
  output logic                     strapMismatch
);
  code_lock_pkg::lockStrobe_t strobes;

  code_lock_ctl #(.NUM_LOCK_BITS(NUM_LOCK_BITS)) u_ctl (
    .lockBits(lockBits),
    .strobes (strobes)
  );

  code_lock_dp u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .extAccessPin    (extAccessPin),
    .reqTableRead    (reqTableRead),
    .reqProgram      (reqProgram),
    .reqVerify       (reqVerify),
    .strobes         (strobes),
    .grantTableRead  (grantTableRead),
    .grantProgram    (grantProgram),
    .grantVerify     (grantVerify),
    .extAccessLatched(extAccessLatched),
    .fetchExternal   (fetchExternal),
    .extFetchBlocked (extFetchBlocked),
    .strapMismatch   (strapMismatch)
  );
endmodule

// File: rtl/code_lock_ctrl_chk.sv
module code_lock_ctrl_chk #(
  parameter int NUM_LOCK_BITS = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_LOCK_BITS-1:0] lockBits,
  input logic                     extAccessPin,
  input logic                     reqTableRead,
  input logic                     reqProgram,
  input logic                     reqVerify,
  input logic                     grantTableRead,
  input logic                     grantProgram,
  input logic                     grantVerify,
  input logic                     extAccessLatched,
  input logic                     fetchExternal,
  input logic                     extFetchBlocked,
  input logic                     strapMismatch
);
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(extAccessLatched));

  p_prog_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    grantProgram |-> (reqProgram && lockBits == '0));

  p_tbl_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    grantTableRead |-> (reqTableRead && lockBits == '0));

  p_verify_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    grantVerify |-> (reqVerify && lockBits[NUM_LOCK_BITS-1:1] == '0));

  p_top_no_ext_r5: assert property (@(posedge clk) disable iff (!rstN)
    lockBits[NUM_LOCK_BITS-1] |-> !fetchExternal);

  p_mismatch_r8: assert property (@(posedge clk) disable iff (!rstN)
    strapMismatch |-> (lockBits != '0 && extAccessLatched != extAccessPin));

  p_locked_fetch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lockBits != '0 && !lockBits[NUM_LOCK_BITS-1]) |-> (fetchExternal == !extAccessLatched));

  p_block_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchExternal && extFetchBlocked));
endmodule

bind code_lock_ctrl code_lock_ctrl_chk #(.NUM_LOCK_BITS(NUM_LOCK_BITS)) u_chk (.*);

// File: tb/code_lock_ctrl_bench.sv
module code_lock_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] lockBits = 3'b000;
  logic extAccessPin = 1'b1;
  logic reqTableRead = 1'b0, reqProgram = 1'b0, reqVerify = 1'b0;
  logic grantTableRead, grantProgram, grantVerify;
  logic extAccessLatched, fetchExternal, extFetchBlocked, strapMismatch;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  code_lock_ctrl #(.NUM_LOCK_BITS(3)) u_code_lock_ctrl (
    .clk(clk), .rstN(rstN), .lockBits(lockBits), .extAccessPin(extAccessPin),
    .reqTableRead(reqTableRead), .reqProgram(reqProgram), .reqVerify(reqVerify),
    .grantTableRead(grantTableRead), .grantProgram(grantProgram),
    .grantVerify(grantVerify), .extAccessLatched(extAccessLatched),
    .fetchExternal(fetchExternal), .extFetchBlocked(extFetchBlocked),
    .strapMismatch(strapMismatch)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // apply settings at a falling edge, look 1 ns later
  task automatic drive(input logic [2:0] lb, input logic pin, input logic [2:0] req);
    @(negedge clk);
    lockBits = lb; extAccessPin = pin;
    {reqTableRead, reqProgram, reqVerify} = req;
    #1;
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rstN = 1'b0; extAccessPin = pin;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    chk("R6 capture high", {3'b0, extAccessLatched}, 4'b0001);
    chk("R11 idle grants", {1'b0, grantTableRead, grantProgram, grantVerify}, 4'b0000);
  endtask

  task automatic t_level0;
    drive(3'b000, 1'b1, 3'b111);
    chk("R2 all granted", {1'b0, grantTableRead, grantProgram, grantVerify}, 4'b0111);
    chk("R2 pin high internal", {3'b0, fetchExternal}, 4'b0000);
    drive(3'b000, 1'b0, 3'b111);
    chk("R2 pin low external", {3'b0, fetchExternal}, 4'b0001);
    chk("R8 no mismatch unlocked", {3'b0, strapMismatch}, 4'b0000);
  endtask

  task automatic t_level1;
    drive(3'b001, 1'b1, 3'b111);
    chk("R3 R4 level1 grants", {1'b0, grantTableRead, grantProgram, grantVerify}, 4'b0001);
    drive(3'b001, 1'b0, 3'b000);
    chk("R7 live pin ignored", {3'b0, fetchExternal}, 4'b0000);
    chk("R8 mismatch raised", {3'b0, strapMismatch}, 4'b0001);
    repeat (2) @(negedge clk);
    chk("R6 held after reset", {3'b0, extAccessLatched}, 4'b0001);
    drive(3'b001, 1'b1, 3'b000);
    chk("R8 mismatch cleared", {3'b0, strapMismatch}, 4'b0000);
  endtask

  task automatic t_recapture;
    lockBits = 3'b001;
    do_reset(1'b0);
    chk("R6 capture low", {3'b0, extAccessLatched}, 4'b0000);
    drive(3'b001, 1'b1, 3'b000);
    chk("R7 latched low external", {2'b0, fetchExternal, strapMismatch}, 4'b0011);
    repeat (3) @(negedge clk);
    chk("R6 stays low", {3'b0, extAccessLatched}, 4'b0000);
  endtask

  task automatic t_level2;
    drive(3'b011, 1'b1, 3'b111);
    chk("R4 verify refused", {1'b0, grantTableRead, grantProgram, grantVerify}, 4'b0000);
    chk("R1 level2 external fetch", {2'b0, fetchExternal, extFetchBlocked}, 4'b0010);
  endtask

  task automatic t_level3;
    drive(3'b111, 1'b0, 3'b000);
    chk("R5 top blocks external", {2'b0, fetchExternal, extFetchBlocked}, 4'b0001);
    do_reset(1'b1);
    drive(3'b111, 1'b1, 3'b000);
    chk("R5 top internal no block", {2'b0, fetchExternal, extFetchBlocked}, 4'b0000);
  endtask

  task automatic t_illegal;
    do_reset(1'b0);
    drive(3'b010, 1'b1, 3'b111);
    chk("R10 010 acts level2", {grantTableRead, grantProgram, grantVerify, fetchExternal}, 4'b0001);
    drive(3'b100, 1'b1, 3'b111);
    chk("R10 100 acts level3", {grantVerify, fetchExternal, extFetchBlocked, strapMismatch}, 4'b0011);
    drive(3'b110, 1'b0, 3'b010);
    chk("R10 110 acts level3", {grantProgram, fetchExternal, extFetchBlocked, 1'b0}, 4'b0010);
  endtask

  task automatic t_same_cycle;
    drive(3'b000, 1'b1, 3'b000);
    @(posedge clk); #2;
    {reqTableRead, reqProgram, reqVerify} = 3'b110;
    #1;
    chk("R9 granted before edge", {1'b0, grantTableRead, grantProgram, grantVerify}, 4'b0110);
    lockBits = 3'b001;
    #1;
    chk("R9 refused before edge", {1'b0, grantTableRead, grantProgram, grantVerify}, 4'b0000);
    {reqTableRead, reqProgram, reqVerify} = 3'b000;
    lockBits = 3'b000;
    #1;
    chk("R11 no request no grant", {1'b0, grantTableRead, grantProgram, grantVerify}, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_level0();
    t_level1();
    t_recapture();
    t_level2();
    t_level3();
    t_illegal();
    t_same_cycle();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule